// File: doc/BRIEF.md
# Configurable registered command buffer

This block registers the address and command lines of a memory module on the rising clock edge and drives them toward the memory devices. A static mode input picks one of two fan-out shapes. In the wide shape every one of the 25 input positions feeds its own output. In the duplicated shape only the low 14 positions are used, and each registered bit drives two copies: one on bank A and one on bank B. In the duplicated shape a second static input picks one of two layouts. The layout decides which input positions carry the clock-enable and termination commands.

Two active-low chip-select inputs gate the data outputs. When both are high, the gated outputs keep their values. The clock-enable and termination positions of the active duplicated layout are not gated, and neither is the registered chip-select copy. An asynchronous active-low reset clears every register at once and takes priority over the gating. If the second select is tied low, gating never happens, and the first select behaves as a plain registered input.

Top module: `cmd_regbuf`

## Requirements
- R1: With `mode_dup` low, `q_a[i]` equals `d_in[i]` sampled at the previous rising edge for all 25 bits whenever a select input is low, and `q_b` is all zero.
- R2: With `mode_dup` high, `q_a[i]` and `q_b[i]` both equal the registered `d_in[i]` for bits 0..13. `q_a[24:14]` is zero and `d_in[24:14]` has no effect on any output.
- R3: `rst_n` low clears `q_a`, `q_b`, `qcs_a_n` and `qcs_b_n` to zero at once, without waiting for a clock edge.
- R4: When `sel_dram_n` and `sel_reg_n` are both high at an edge, every gated data output keeps its value across that edge.
- R5: When either `sel_dram_n` or `sel_reg_n` is low at an edge, every data output loads its new value at that edge.
- R6: `qcs_a_n` and `qcs_b_n` are equal and take the value `sel_dram_n` had at the previous edge, whatever the gating state.
- R7: Reset clears the outputs even while both selects are high.
- R8: Duplicated mode with `place_b` low: bits 0 (clock-enable) and 3 (termination) load at every edge, even while the other bits are held.
- R9: Duplicated mode with `place_b` high: bits 10 (termination) and 13 (clock-enable) load at every edge, while bits 0 and 3 are gated like the rest.
- R10: After `rst_n` rises, all outputs stay zero for as long as `d_in` and `sel_dram_n` stay zero.
- R11: With `mode_dup` low, no bit is exempt from gating, and all 25 bits of `q_a` hold when both selects are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dup | input | 1 | 0: 25-bit one-to-one, 1: 14-bit duplicated (static) |
| place_b | input | 1 | Layout in duplicated mode: 0 first, 1 second (static) |
| sel_dram_n | input | 1 | Active-low chip select, also registered onto qcs outputs |
| sel_reg_n | input | 1 | Active-low second select; tie low to disable gating |
| d_in | input | 25 | Address/command inputs, position p at bit p-1 |
| q_a | output | 25 | Bank A outputs |
| q_b | output | 14 | Bank B outputs (duplicated mode only) |
| qcs_a_n | output | 1 | Registered chip select, copy A |
| qcs_b_n | output | 1 | Registered chip select, copy B |

## Verification
The hardest case to reach is a held cycle in duplicated mode. In that cycle most bits must keep their values while the two command positions of the chosen layout still load, and the register must already hold values that differ from the new inputs. The stimulus first loads the register with a changing arithmetic pattern. It then cycles both selects through all four combinations on every edge, and it repeats this for each mode and layout pair. Each configuration change is made inside a reset. That reset is asserted between clock edges while the outputs are held.

// File: rtl/cmd_regbuf_pkg.sv
// Package: shared encodings for the configurable command buffer.
// Assumes: mode and layout inputs are static outside reset.
package cmd_regbuf_pkg;
    typedef enum logic {
        FAN_ONE = 1'b0,
        FAN_DUP = 1'b1
    } fan_mode_e;

    typedef enum logic {
        LAYOUT_FIRST  = 1'b0,
        LAYOUT_SECOND = 1'b1
    } layout_e;
endpackage

// File: rtl/cmd_gate.sv
// cmd_gate: makes one load enable per register bit from the two selects.
// Assumes: mode/layout static; positions given as bit indices below WIDE_BITS.
module cmd_gate
    import cmd_regbuf_pkg::*;
#(
    parameter int WIDE_BITS = 25,
    parameter int L1_CKE    = 0,
    parameter int L1_ODT    = 3,
    parameter int L2_ODT    = 10,
    parameter int L2_CKE    = 13
) (
    input  logic                 mode_dup,
    input  logic                 place_b,
    input  logic                 sel_dram_n,
    input  logic                 sel_reg_n,
    output logic [WIDE_BITS-1:0] load_en
);
    fan_mode_e fmode;
    layout_e   lay;
    logic      hold;

    assign fmode = fan_mode_e'(mode_dup);
    assign lay   = layout_e'(place_b);
    assign hold  = sel_dram_n & sel_reg_n;

    for (genvar i = 0; i < WIDE_BITS; i++) begin : g_bit
        localparam bit IN_L1 = (i == L1_CKE) || (i == L1_ODT);
        localparam bit IN_L2 = (i == L2_CKE) || (i == L2_ODT);
        logic exempt;
        // Purpose: flag this bit as a command that bypasses the hold.
        always_comb begin
            exempt = 1'b0;
            if (fmode == FAN_DUP) begin
                exempt = (lay == LAYOUT_FIRST) ? IN_L1 : IN_L2;
            end
        end
        assign load_en[i] = ~hold | exempt;
    end
endmodule

// File: rtl/cmd_capture.sv
// cmd_capture: input register bank with per-bit load enable and chip-select flop.
// Assumes: rst_n is asynchronous and clears everything.
module cmd_capture #(
    parameter int WIDE_BITS = 25
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDE_BITS-1:0] load_en,
    input  logic [WIDE_BITS-1:0] d_in,
    input  logic                 sel_dram_n,
    output logic [WIDE_BITS-1:0] cap_q,
    output logic                 cs_q
);
    for (genvar i = 0; i < WIDE_BITS; i++) begin : g_ff
        // Purpose: capture one input bit when its enable is set.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cap_q[i] <= 1'b0;
            end else if (load_en[i]) begin
                cap_q[i] <= d_in[i];
            end
        end
    end

    // Purpose: register the chip select on every edge, never gated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
        end else begin
            cs_q <= sel_dram_n;
        end
    end
endmodule

// File: rtl/cmd_fanout.sv
// cmd_fanout: maps the register onto bank A and bank B for the chosen mode.
// Assumes: DUP_BITS <= WIDE_BITS; mode is static.
module cmd_fanout
    import cmd_regbuf_pkg::*;
#(
    parameter int WIDE_BITS = 25,
    parameter int DUP_BITS  = 14
) (
    input  logic                 mode_dup,
    input  logic [WIDE_BITS-1:0] cap_q,
    output logic [WIDE_BITS-1:0] q_a,
    output logic [DUP_BITS-1:0]  q_b
);
    fan_mode_e fmode;
    assign fmode = fan_mode_e'(mode_dup);

    for (genvar i = 0; i < WIDE_BITS; i++) begin : g_a
        if (i < DUP_BITS) begin : g_shared
            assign q_a[i] = cap_q[i];
        end else begin : g_wide_only
            // Purpose: upper bank A bits exist only in the one-to-one mode.
            assign q_a[i] = (fmode == FAN_ONE) ? cap_q[i] : 1'b0;
        end
    end

    for (genvar j = 0; j < DUP_BITS; j++) begin : g_b
        // Purpose: bank B copies are driven only in the duplicated mode.
        assign q_b[j] = (fmode == FAN_DUP) ? cap_q[j] : 1'b0;
    end
endmodule

// File: rtl/cmd_regbuf.sv
// cmd_regbuf: configurable registered command buffer (top).
// Assumes: mode_dup/place_b change only while rst_n is low.
module cmd_regbuf #(
    parameter int WIDE_BITS = 25,
    parameter int DUP_BITS  = 14,
    parameter int L1_CKE    = 0,
    parameter int L1_ODT    = 3,
    parameter int L2_ODT    = 10,
    parameter int L2_CKE    = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_dup,
    input  logic                 place_b,
    input  logic                 sel_dram_n,
    input  logic                 sel_reg_n,
    input  logic [WIDE_BITS-1:0] d_in,
    output logic [WIDE_BITS-1:0] q_a,
    output logic [DUP_BITS-1:0]  q_b,
    output logic                 qcs_a_n,
    output logic                 qcs_b_n
);
    logic [WIDE_BITS-1:0] load_en;
    logic [WIDE_BITS-1:0] cap_q;
    logic                 cs_q;

    cmd_gate #(
        .WIDE_BITS(WIDE_BITS), .L1_CKE(L1_CKE), .L1_ODT(L1_ODT),
        .L2_ODT(L2_ODT), .L2_CKE(L2_CKE)
    ) u_gate (
        .mode_dup  (mode_dup),
        .place_b   (place_b),
        .sel_dram_n(sel_dram_n),
        .sel_reg_n (sel_reg_n),
        .load_en   (load_en)
    );

    cmd_capture #(.WIDE_BITS(WIDE_BITS)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .d_in      (d_in),
        .sel_dram_n(sel_dram_n),
        .cap_q     (cap_q),
        .cs_q      (cs_q)
    );

    cmd_fanout #(.WIDE_BITS(WIDE_BITS), .DUP_BITS(DUP_BITS)) u_fan (
        .mode_dup(mode_dup),
        .cap_q   (cap_q),
        .q_a     (q_a),
        .q_b     (q_b)
    );

    assign qcs_a_n = cs_q;
    assign qcs_b_n = cs_q;
endmodule

// File: rtl/cmd_regbuf_chk.sv
// cmd_regbuf_chk: port-level properties of cmd_regbuf, attached by bind.
module cmd_regbuf_chk #(
    parameter int WIDE_BITS = 25,
    parameter int DUP_BITS  = 14,
    parameter int L1_CKE    = 0,
    parameter int L1_ODT    = 3,
    parameter int L2_ODT    = 10,
    parameter int L2_CKE    = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mode_dup,
    input logic                 place_b,
    input logic                 sel_dram_n,
    input logic                 sel_reg_n,
    input logic [WIDE_BITS-1:0] d_in,
    input logic [WIDE_BITS-1:0] q_a,
    input logic [DUP_BITS-1:0]  q_b,
    input logic                 qcs_a_n,
    input logic                 qcs_b_n
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !qcs_a_n && !qcs_b_n)); // R3

    AST_ONE_B_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_dup |-> (q_b == '0)); // R1

    AST_DUP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_dup |-> (q_a[DUP_BITS-1:0] == q_b && q_a[WIDE_BITS-1:DUP_BITS] == '0)); // R2

    AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dup && sel_dram_n && sel_reg_n) |=> $stable(q_a)); // R11

    AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_dup && (!sel_dram_n || !sel_reg_n)) |=> (q_a == $past(d_in))); // R5

    AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (qcs_a_n == $past(sel_dram_n) && qcs_b_n == qcs_a_n)); // R6

    AST_LAYOUT1_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dup && !place_b) |=>
            (q_a[L1_CKE] == $past(d_in[L1_CKE]) && q_a[L1_ODT] == $past(d_in[L1_ODT]))); // R8

    AST_LAYOUT2_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_dup && place_b) |=>
            (q_a[L2_CKE] == $past(d_in[L2_CKE]) && q_a[L2_ODT] == $past(d_in[L2_ODT]))); // R9
endmodule

bind cmd_regbuf cmd_regbuf_chk #(
    .WIDE_BITS(WIDE_BITS), .DUP_BITS(DUP_BITS), .L1_CKE(L1_CKE), .L1_ODT(L1_ODT),
    .L2_ODT(L2_ODT), .L2_CKE(L2_CKE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_dup(mode_dup), .place_b(place_b),
    .sel_dram_n(sel_dram_n), .sel_reg_n(sel_reg_n), .d_in(d_in),
    .q_a(q_a), .q_b(q_b), .qcs_a_n(qcs_a_n), .qcs_b_n(qcs_b_n)
);

// File: tb/cmd_regbuf_test.sv
// cmd_regbuf_test: sweeps every mode/layout pair and every select pair.
module cmd_regbuf_test;
    localparam int W = 25;
    localparam int D = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_dup = 1'b0;
    logic         place_b = 1'b0;
    logic         sel_dram_n = 1'b0;
    logic         sel_reg_n = 1'b0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_a;
    logic [D-1:0] q_b;
    logic         qcs_a_n;
    logic         qcs_b_n;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] mreg;
    logic         mcs;

    always #5 clk = ~clk;

    cmd_regbuf uut (
        .clk(clk), .rst_n(rst_n), .mode_dup(mode_dup), .place_b(place_b),
        .sel_dram_n(sel_dram_n), .sel_reg_n(sel_reg_n), .d_in(d_in),
        .q_a(q_a), .q_b(q_b), .qcs_a_n(qcs_a_n), .qcs_b_n(qcs_b_n)
    );

    function automatic bit exempt(input logic m, input logic p, input int i);
        if (!m) return 1'b0;
        if (!p) return (i == 0) || (i == 3);
        return (i == 10) || (i == 13);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        logic [W-1:0] ea;
        logic [D-1:0] eb;
        if (mode_dup) begin
            ea = {{(W-D){1'b0}}, mreg[D-1:0]};
            eb = mreg[D-1:0];
        end else begin
            ea = mreg;
            eb = '0;
        end
        check({req, " q_a"}, 64'(q_a), 64'(ea));
        check({req, " q_b"}, 64'(q_b), 64'(eb));
        check("R6 qcs", 64'({qcs_a_n, qcs_b_n}), 64'({mcs, mcs}));
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic step(input logic [W-1:0] d, input logic dcs, input logic csr);
        bit hold;
        string req;
        d_in = d; sel_dram_n = dcs; sel_reg_n = csr;
        @(posedge clk);
        hold = dcs && csr;
        for (int i = 0; i < W; i++) begin
            if (!hold || exempt(mode_dup, place_b, i)) mreg[i] = d[i];
        end
        mcs = dcs;
        @(negedge clk);
        if (hold) req = mode_dup ? (place_b ? "R4+R9" : "R4+R8") : "R4+R11";
        else      req = mode_dup ? "R5+R2" : "R5+R1";
        check_outputs(req);
    endtask

    task automatic enter_config(input logic m, input logic p);
        rst_n = 1'b0;
        #1;
        mreg = '0; mcs = 1'b0;
        check_outputs("R3");
        mode_dup = m; place_b = p;
        d_in = '0; sel_dram_n = 1'b0; sel_reg_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) step('0, 1'b0, 1'b0); // R10 quiet after release
        check_outputs("R10");
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mreg = '0; mcs = 1'b0;
        @(negedge clk);
        check_outputs("R3 reset state");
        for (int cfg = 0; cfg < 4; cfg++) begin
            enter_config(cfg[1], cfg[0]);
            for (int k = 0; k < 48; k++) begin
                logic [31:0] pat;
                pat = (32'(k) * 32'h0019_6A5B + 32'(cfg) * 32'd977) ^ (32'(k) << 9);
                step(pat[W-1:0], k[0], k[1]);
            end
            // Exempt bits only: full-width flip under hold.
            step({W{1'b1}}, 1'b0, 1'b0);
            step('0, 1'b1, 1'b1);
            // R7: reset between edges while both selects are high.
            @(posedge clk);
            #2 rst_n = 1'b0;
            #1;
            mreg = '0; mcs = 1'b0;
            check_outputs("R7");
            @(negedge clk);
        end
        // R2: upper inputs in duplicated mode reach nothing.
        enter_config(1'b1, 1'b0);
        step({{(W-D){1'b1}}, {D{1'b0}}}, 1'b0, 1'b0);
        check("R2 upper ignored", 64'({q_a, q_b}), 64'(0));
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule